// File: doc/BRIEF.md
# Processor Performance Monitor

This block is a small performance monitor for a processor core. It holds one dedicated cycle counter and two event counters, each 32 bits wide. Each event counter is pointed at one bit of a vector of single-cycle event pulses by an 8-bit event code. Software reaches the block through a four-address register port with a single-cycle write strobe and a combinational read path. Address 0 holds the control/status word. Addresses 1, 2 and 3 hold the cycle counter, event counter 0 and event counter 1.

One global enable bit starts and stops all three counters together; there is no per-counter enable. To stop a single event counter, software selects an event code that never fires. Code 0x20 is reserved as such a parking code. Each counter sets a sticky overflow flag when it wraps. Software clears a flag by writing 1 to it, so writing back a control word just read clears the reported flags and changes nothing else. One interrupt output is raised while any flagged counter has its interrupt enable set. The cycle counter can optionally advance only once per 64 counted cycles.

Top module: `perf_mon`

## Requirements
- R1: After reset, the control word and all three counters read 0 and `irq_o` is low.
- R2: While control bit 0 (global enable) is 0, no counter advances, whatever `cyc_tick_i` and `evt_i` do.
- R3: With bit 0 set and bit 3 clear, the cycle counter (address 1) adds one for each clock in which `cyc_tick_i` is high.
- R4: With bit 3 set, the cycle counter adds one for every 64 enabled clocks with `cyc_tick_i` high. The divider restarts from zero when the cycle-counter reset bit is written.
- R5: Event counter 0 (address 2) uses the code in control bits [27:20], and event counter 1 (address 3) uses the code in bits [19:12]. While enabled, a counter adds one in each clock where `evt_i[code]` is high. Both counters may select the same code.
- R6: A code with no matching `evt_i` bit (code >= NUM_EVT, including 0xFF) never increments a counter. Code 0x20 always parks the counter.
- R7: Writing 1 to control bit 1 clears both event counters, and writing 1 to bit 2 clears the cycle counter. Neither bit affects the other counters, and both bits always read back as 0.
- R8: A write to address 1, 2 or 3 loads that counter with the written value. The write wins over an increment in the same clock, so writing 0 clears the counter.
- R9: Overflow flags sit in bits 10 (cycle), 8 (event 0) and 9 (event 1). A flag is set when its counter wraps and stays set until a control write with a 1 in that bit. Writing back a control word just read clears only those flags and leaves every other field unchanged.
- R10: `irq_o` is high exactly when some overflow flag is set together with its interrupt enable: bit 6 for the cycle counter, bit 4 for event counter 0, bit 5 for event counter 1.
- R11: Counters are 32 bits and wrap from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick_i | input | 1 | Core-cycle qualifier for the cycle counter |
| evt_i | input | NUM_EVT | Single-cycle event pulses, indexed by event code |
| reg_wr_i | input | 1 | Single-cycle register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Combined overflow interrupt |

## Verification
Each piece of internal state is visible at the ports one clock after it changes. A wrong enable or event selection shows up as a counter read that differs from the bench's count of qualifying pulses, right after the run. A divider that has lost its phase moves the first cycle-counter step away from tick 64, which a read at ticks 63 and 64 exposes. A flag that is set late, lost or not cleared shows up in the control word and on `irq_o` in the clock after the wrap or the write.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
    localparam int NCTR    = 3;
    localparam int CTR_CYC = 0;
    localparam int CTR_EV0 = 1;
    localparam int CTR_EV1 = 2;
    localparam int SEL_W   = 8;

    localparam int B_EN      = 0;
    localparam int B_RST_EV  = 1;
    localparam int B_RST_CYC = 2;
    localparam int B_DIV     = 3;
    localparam int SEL0_LSB  = 20;
    localparam int SEL1_LSB  = 12;

    // interrupt-enable bit of counter index i
    function automatic int ie_bit(input int i);
        return (i == CTR_CYC) ? 6 : (3 + i);
    endfunction

    // overflow-flag bit of counter index i
    function automatic int flag_bit(input int i);
        return ie_bit(i) + 4;
    endfunction
endpackage

// File: rtl/perf_prescale.sv
module perf_prescale #(
    parameter int RATIO = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic hit_o
);
    localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [PW-1:0] cnt_q;

    assign hit_o = run_i && (cnt_q == PW'(RATIO - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/perf_evt_sel.sv
module perf_evt_sel #(
    parameter int NUM_EVT   = 32,
    parameter int SEL_W     = 8,
    parameter int PARK_CODE = 32
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               hit_o
);
    always_comb begin
        hit_o = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (int'(sel_i) == i) hit_o = evt_i[i];
        end
        if (int'(sel_i) == PARK_CODE) hit_o = 1'b0;
    end
endmodule

// File: rtl/perf_ctr.sv
module perf_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    assign cnt_o  = cnt_q;
    assign wrap_o = inc_i && !clr_i && !ld_i && (&cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/perf_mon.sv
module perf_mon
    import perf_mon_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int NUM_EVT   = 32,
    parameter int DIV_RATIO = 64,
    parameter int PARK_CODE = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_tick_i,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic               irq_o
);
    logic                       en_q, div_q;
    logic [NCTR-1:0]            ie_q, ovf_q;
    logic [1:0][SEL_W-1:0]      sel_q;
    logic [NCTR-1:0][REG_W-1:0] cnt_w;
    logic [NCTR-1:0]            inc, wrap, clr, ld;
    logic [1:0]                 ev_hit;
    logic                       wr_ctrl, rst_ev, rst_cyc, pre_hit;
    logic [NCTR-1:0]            flag_clr;
    logic [REG_W-1:0]           ctrl_word;

    assign wr_ctrl = reg_wr_i && (reg_addr_i == 2'd0);
    assign rst_ev  = wr_ctrl && reg_wdata_i[B_RST_EV];
    assign rst_cyc = wr_ctrl && reg_wdata_i[B_RST_CYC];

    always_comb begin
        for (int i = 0; i < NCTR; i++) begin
            flag_clr[i] = wr_ctrl && reg_wdata_i[flag_bit(i)];
        end
    end

    // control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            div_q <= 1'b0;
            ie_q  <= '0;
            sel_q <= '0;
        end else if (wr_ctrl) begin
            en_q     <= reg_wdata_i[B_EN];
            div_q    <= reg_wdata_i[B_DIV];
            sel_q[0] <= reg_wdata_i[SEL0_LSB +: SEL_W];
            sel_q[1] <= reg_wdata_i[SEL1_LSB +: SEL_W];
            for (int i = 0; i < NCTR; i++) ie_q[i] <= reg_wdata_i[ie_bit(i)];
        end
    end

    // sticky overflow flags; a wrap in the clearing cycle wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= '0;
        else        ovf_q <= (ovf_q & ~flag_clr) | wrap;
    end

    perf_prescale #(.RATIO(DIV_RATIO)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (rst_cyc || !div_q),
        .run_i (en_q && div_q && cyc_tick_i),
        .hit_o (pre_hit)
    );

    for (genvar j = 0; j < 2; j++) begin : g_sel
        perf_evt_sel #(
            .NUM_EVT   (NUM_EVT),
            .SEL_W     (SEL_W),
            .PARK_CODE (PARK_CODE)
        ) u_sel (
            .sel_i (sel_q[j]),
            .evt_i (evt_i),
            .hit_o (ev_hit[j])
        );
    end

    assign inc[CTR_CYC] = en_q && cyc_tick_i && (div_q ? pre_hit : 1'b1);
    assign inc[CTR_EV0] = en_q && ev_hit[0];
    assign inc[CTR_EV1] = en_q && ev_hit[1];

    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
        assign clr[i] = (i == CTR_CYC) ? rst_cyc : rst_ev;
        assign ld[i]  = reg_wr_i && (reg_addr_i == 2'(i + 1));
        perf_ctr #(.W(REG_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (clr[i]),
            .ld_i     (ld[i]),
            .ld_val_i (reg_wdata_i),
            .inc_i    (inc[i]),
            .cnt_o    (cnt_w[i]),
            .wrap_o   (wrap[i])
        );
    end

    always_comb begin
        ctrl_word         = '0;
        ctrl_word[B_EN]   = en_q;
        ctrl_word[B_DIV]  = div_q;
        ctrl_word[SEL0_LSB +: SEL_W] = sel_q[0];
        ctrl_word[SEL1_LSB +: SEL_W] = sel_q[1];
        for (int i = 0; i < NCTR; i++) begin
            ctrl_word[ie_bit(i)]   = ie_q[i];
            ctrl_word[flag_bit(i)] = ovf_q[i];
        end
    end

    always_comb begin
        unique case (reg_addr_i)
            2'd0:    reg_rdata_o = ctrl_word;
            2'd1:    reg_rdata_o = cnt_w[0];
            2'd2:    reg_rdata_o = cnt_w[1];
            default: reg_rdata_o = cnt_w[2];
        endcase
    end

    assign irq_o = |(ovf_q & ie_q);
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk
    import perf_mon_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int PARK_CODE = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr_i,
    input logic [1:0]                 reg_addr_i,
    input logic [REG_W-1:0]           reg_wdata_i,
    input logic [REG_W-1:0]           reg_rdata_o,
    input logic                       irq_o,
    input logic                       en_q,
    input logic [NCTR-1:0]            ie_q,
    input logic [NCTR-1:0]            ovf_q,
    input logic [NCTR-1:0]            inc,
    input logic [1:0][SEL_W-1:0]      sel_q,
    input logic [NCTR-1:0][REG_W-1:0] cnt_w
);
    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !reg_wr_i) |=> $stable(cnt_w));

    // R7
    rst_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == 2'd0) |-> (reg_rdata_o[B_RST_CYC:B_RST_EV] == 2'b00));

    // R6
    park_ev0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_i && int'(sel_q[0]) == PARK_CODE) |=> $stable(cnt_w[CTR_EV0]));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q == '0) |-> !irq_o);

    for (genvar i = 0; i < NCTR; i++) begin : g_a
        // R9
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[i] && !(reg_wr_i && reg_addr_i == 2'd0 && reg_wdata_i[flag_bit(i)]))
            |=> ovf_q[i]);
        // R9
        flag_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inc[i] && (&cnt_w[i]) && !reg_wr_i) |=> ovf_q[i]);
        // R11
        wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inc[i] && (&cnt_w[i]) && !reg_wr_i) |=> (cnt_w[i] == '0));
        // R10
        irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[i] && ie_q[i]) |-> irq_o);
    end
endmodule

bind perf_mon perf_mon_chk #(.REG_W(REG_W), .PARK_CODE(PARK_CODE)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .en_q        (en_q),
    .ie_q        (ie_q),
    .ovf_q       (ovf_q),
    .inc         (inc),
    .sel_q       (sel_q),
    .cnt_w       (cnt_w)
);

// File: tb/perf_mon_tb_top.sv
module perf_mon_tb_top;
    localparam int NE = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_tick_i = 1'b0;
    logic [NE-1:0] evt_i = '0;
    logic          reg_wr_i = 1'b0;
    logic [1:0]    reg_addr_i = 2'd0;
    logic [31:0]   reg_wdata_i = '0;
    logic [31:0]   reg_rdata_o;
    logic          irq_o;

    int nvec = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    perf_mon #(.REG_W(32), .NUM_EVT(NE), .DIV_RATIO(64), .PARK_CODE(32)) dut_i (
        .clk (clk), .rst_n (rst_n), .cyc_tick_i (cyc_tick_i), .evt_i (evt_i),
        .reg_wr_i (reg_wr_i), .reg_addr_i (reg_addr_i), .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o), .irq_o (irq_o)
    );

    function automatic logic [31:0] mk(bit en, bit dv, bit ie0, bit ie1, bit iec,
                                       logic [7:0] s0, logic [7:0] s1, bit re, bit rc);
        logic [31:0] v = '0;
        v[0] = en; v[1] = re; v[2] = rc; v[3] = dv;
        v[4] = ie0; v[5] = ie1; v[6] = iec;
        v[27:20] = s0; v[19:12] = s1;
        return v;
    endfunction

    function automatic bit ev_exp(logic [7:0] sel, logic [NE-1:0] ev);
        return (sel < NE && sel != 8'h20) ? ev[sel] : 1'b0;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        reg_addr_i = a;
        #1;
        v = reg_rdata_o;
    endtask

    task automatic run(int n, logic [7:0] s0, logic [7:0] s1,
                       output int nt, output int n0, output int n1);
        nt = 0; n0 = 0; n1 = 0;
        for (int k = 0; k < n; k++) begin
            cyc_tick_i = 1'($urandom % 2);
            evt_i = $urandom;
            nt += cyc_tick_i;
            n0 += ev_exp(s0, evt_i);
            n1 += ev_exp(s1, evt_i);
            @(negedge clk);
        end
        cyc_tick_i = 1'b0; evt_i = '0;
    endtask

    function automatic logic [7:0] pick();
        int r = $urandom % 10;
        if (r == 0) return 8'h20;
        if (r == 1) return 8'hFF;
        return 8'($urandom % NE);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v, c;
        int nt, n0, n1;
        logic [7:0] s0, s1;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 cyc", v, 0);
        rd(2, v); chk("R1 ev0", v, 0);
        rd(3, v); chk("R1 ev1", v, 0);
        chk("R1 irq", 32'(irq_o), 0);

        // R2 disabled: nothing moves
        run(50, 8'd0, 8'd0, nt, n0, n1);
        rd(1, v); chk("R2 cyc", v, 0);
        rd(2, v); chk("R2 ev0", v, 0);

        // R3 cycle counting every tick
        wr(0, mk(1,0,0,0,0,8'h20,8'h20,0,0));
        cyc_tick_i = 1'b1;
        repeat (10) @(negedge clk);
        cyc_tick_i = 1'b0;
        rd(1, v); chk("R3 cyc 10 ticks", v, 10);

        // R5 R6 random rounds; one round with equal codes
        for (int r = 0; r < 6; r++) begin
            s0 = pick();
            s1 = (r == 2) ? s0 : pick();
            if (r == 3) s0 = 8'h20;
            if (r == 4) s1 = 8'hFF;
            wr(0, mk(0,0,0,0,0,s0,s1,1,1));
            wr(0, mk(1,0,0,0,0,s0,s1,0,0));
            run(150, s0, s1, nt, n0, n1);
            rd(1, v); chk("R3 cyc random", v, 32'(nt));
            rd(2, v); chk("R5 R6 ev0 random", v, 32'(n0));
            rd(3, v); chk("R5 R6 ev1 random", v, 32'(n1));
        end

        // R6 parked code with every event high
        wr(0, mk(0,0,0,0,0,8'h20,8'hFF,1,0));
        wr(0, mk(1,0,0,0,0,8'h20,8'hFF,0,0));
        evt_i = '1;
        repeat (20) @(negedge clk);
        evt_i = '0;
        rd(2, v); chk("R6 park 0x20", v, 0);
        rd(3, v); chk("R6 code 0xFF", v, 0);

        // R4 divide by 64
        wr(0, mk(1,1,0,0,0,8'h20,8'h20,0,1));
        cyc_tick_i = 1'b1;
        repeat (63) @(negedge clk);
        cyc_tick_i = 1'b0;
        rd(1, v); chk("R4 div after 63", v, 0);
        cyc_tick_i = 1'b1;
        @(negedge clk);
        cyc_tick_i = 1'b0;
        rd(1, v); chk("R4 div after 64", v, 1);
        cyc_tick_i = 1'b1;
        repeat (136) @(negedge clk);
        cyc_tick_i = 1'b0;
        rd(1, v); chk("R4 div after 200", v, 3);

        // R7 reset bits are selective
        wr(0, mk(0,0,0,0,0,8'h20,8'h20,0,0));
        wr(1, 32'd100); wr(2, 32'd200); wr(3, 32'd300);
        wr(0, mk(0,0,0,0,0,8'h20,8'h20,1,0));
        rd(1, v); chk("R7 cyc kept", v, 100);
        rd(2, v); chk("R7 ev0 cleared", v, 0);
        rd(3, v); chk("R7 ev1 cleared", v, 0);
        wr(0, mk(0,0,0,0,0,8'h20,8'h20,0,1));
        rd(1, v); chk("R7 cyc cleared", v, 0);
        rd(0, v); chk("R7 reset bits read 0", 32'(v[2:1]), 0);

        // R8 write beats increment
        wr(0, mk(1,0,0,0,0,8'd3,8'h20,0,0));
        evt_i[3] = 1'b1;
        wr(2, 32'h55);
        evt_i = '0;
        rd(2, v); chk("R8 load wins", v, 32'h55);
        wr(2, 32'h0);
        rd(2, v); chk("R8 write zero", v, 0);

        // R9 R11 cycle counter overflow with interrupt
        wr(0, mk(0,0,0,0,0,8'h20,8'h20,0,0));
        wr(1, 32'hFFFF_FFFE);
        wr(0, mk(1,0,0,0,1,8'h20,8'h20,0,0));
        cyc_tick_i = 1'b1; @(negedge clk); cyc_tick_i = 1'b0;
        rd(1, v); chk("R11 at max", v, 32'hFFFF_FFFF);
        chk("R10 no irq before wrap", 32'(irq_o), 0);
        cyc_tick_i = 1'b1; @(negedge clk); cyc_tick_i = 1'b0;
        rd(1, v); chk("R11 wrapped to 0", v, 0);
        rd(0, c); chk("R9 flag10 set", 32'(c[10]), 1);
        chk("R10 irq after wrap", 32'(irq_o), 1);
        repeat (3) @(negedge clk);
        rd(0, v); chk("R9 flag sticky", 32'(v[10]), 1);
        wr(0, c);
        rd(0, v); chk("R9 write-back clears only flag", v, c & ~32'h400);
        chk("R10 irq dropped", 32'(irq_o), 0);

        // R10 enable gating on event counter 0 overflow
        wr(0, mk(0,0,0,0,0,8'd5,8'h20,0,0));
        wr(2, 32'hFFFF_FFFF);
        wr(0, mk(1,0,0,0,0,8'd5,8'h20,0,0));
        evt_i[5] = 1'b1; @(negedge clk); evt_i = '0;
        rd(0, v); chk("R9 flag8 set", 32'(v[8]), 1);
        chk("R10 irq masked", 32'(irq_o), 0);
        wr(0, mk(1,0,1,0,0,8'd5,8'h20,0,0));
        chk("R10 irq unmasked", 32'(irq_o), 1);
        rd(2, v); chk("R11 ev0 wrapped", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule